// File: doc/BRIEF.md
# Strided and Indexed Vector Address Generator

This block walks a vector load or store one element at a time and produces the memory address of each element for a memory made of word-interleaved banks. A start pulse captures a base address, a length, a mode and a stride. In strided mode the addresses advance by a fixed signed step. In indexed (gather/scatter) mode each address is the base plus an offset read from an index vector. The index vector is reached through a read port: the block names the element it needs, and the index comes back in the same cycle.

Each bank stays occupied for a fixed number of cycles after an access starts. The block keeps one countdown per bank and only issues an element when the bank it maps to is idle. At most one access starts per cycle across the whole memory. A conflict holds the current element in place until its bank is free. Every request carries its element number, so returning data can be written into the correct slot of a vector register. Bank occupancy carries over from one vector to the next.

Top module: `vec_agu`

## Requirements
- R1: After reset, `req_valid`, `busy` and `done` are all 0.
- R2: In strided mode, element k has address base + k*stride, taken modulo 2^ADDR_W with the stride treated as two's complement. Elements are issued in order 0, 1, 2, ..., and `req_elem` equals k.
- R3: `req_bank` equals the low log2(NBANK) bits of `req_addr` (bits 3:0 when NBANK is 16).
- R4: A request that starts in cycle t makes its bank unavailable until cycle t+BANK_LAT. While the element's bank is unavailable, no request is made and the element does not advance.
- R5: With stride 1 and NBANK >= BANK_LAT, a vector with no earlier bank conflicts issues one element in each consecutive cycle.
- R6: With a stride equal to NBANK, successive elements are issued exactly BANK_LAT cycles apart.
- R7: In indexed mode (`mode_index`=1), `idx_sel` names the current element k, and the address is base + `idx_val` (the index zero-extended).
- R8: Exactly min(vlen, MAXLEN) requests are made. `done` is a one-cycle pulse in the cycle after the last request, and `busy` is low from that cycle onward.
- R9: A start with vlen = 0 makes no requests and pulses `done` in the next cycle.
- R10: `start` is ignored while `busy` is high; the running vector continues unchanged.
- R11: Bank occupancy carries over between vectors. The first element of a new vector waits for a bank that an earlier vector left busy.
- R12: A vlen above MAXLEN is clamped to MAXLEN elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector (accepted only when idle) |
| mode_index | input | 1 | 0 = strided, 1 = indexed |
| base_addr | input | ADDR_W | Base word address, captured at start |
| stride | input | ADDR_W | Signed word step, captured at start |
| vlen | input | LEN_W | Number of elements, captured at start |
| idx_sel | output | EW | Element whose index is being read |
| idx_val | input | IDX_W | Index value for `idx_sel`, same cycle |
| req_valid | output | 1 | An element access starts this cycle |
| req_addr | output | ADDR_W | Word address of the element |
| req_bank | output | BW | Bank number of the element |
| req_elem | output | EW | Element number of the request |
| busy | output | 1 | A vector is in progress |
| done | output | 1 | One-cycle pulse when a vector finishes |

## Verification
The bench builds the block with its defaults: 16 banks, an 11-cycle bank occupancy, 64-element registers and 32-bit addresses. Because 16 is at least 11, a unit stride runs without stalls. A stride of 2 touches only 8 banks, so it stalls for 3 of every 11 cycles. A stride of 16 hits a single bank and runs at one element per 11 cycles. All three throughput regimes are therefore within reach. The 64-element limit is small enough that the clamp, a full-length vector and an index vector with deliberate same-bank collisions all fit in short runs.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic {
    AGU_STRIDED = 1'b0,
    AGU_INDEXED = 1'b1
  } agu_mode_e;
endpackage

// File: rtl/vagu_ctrl.sv
module vagu_ctrl #(
  parameter int MAXLEN = 64,
  localparam int LEN_W = $clog2(MAXLEN + 1),
  localparam int EW    = $clog2(MAXLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] vlen,
  input  logic             issue,
  output logic             start_acc,
  output logic             busy,
  output logic             done,
  output logic [EW-1:0]    elem
);
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             busy_q, done_q;
  logic             last;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    return (v > LEN_W'(MAXLEN)) ? LEN_W'(MAXLEN) : v;
  endfunction

  assign start_acc = start && !busy_q;
  assign last      = (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        len_q <= clamp_len(vlen);
        cnt_q <= '0;
        if (clamp_len(vlen) == '0) done_q <= 1'b1;
        else                       busy_q <= 1'b1;
      end else if (issue) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign elem = cnt_q[EW-1:0];
endmodule

// File: rtl/vagu_addr.sv
module vagu_addr
  import vagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              issue,
  input  logic              mode_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] stride_in,
  input  logic [IDX_W-1:0]  idx_val,
  output logic [ADDR_W-1:0] addr
);
  agu_mode_e         mode_q;
  logic [ADDR_W-1:0] base_q, stride_q, cur_q;

  function automatic logic [ADDR_W-1:0] stride_next(input logic [ADDR_W-1:0] a,
                                                     input logic [ADDR_W-1:0] s);
    return a + s;
  endfunction

  function automatic logic [ADDR_W-1:0] index_addr(input logic [ADDR_W-1:0] b,
                                                    input logic [IDX_W-1:0]  i);
    return b + ADDR_W'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= AGU_STRIDED;
      base_q   <= '0;
      stride_q <= '0;
      cur_q    <= '0;
    end else if (start_acc) begin
      mode_q   <= agu_mode_e'(mode_in);
      base_q   <= base_in;
      stride_q <= stride_in;
      cur_q    <= base_in;
    end else if (issue && mode_q == AGU_STRIDED) begin
      cur_q <= stride_next(cur_q, stride_q);
    end
  end

  assign addr = (mode_q == AGU_INDEXED) ? index_addr(base_q, idx_val) : cur_q;
endmodule

// File: rtl/vagu_banks.sv
module vagu_banks #(
  parameter int NBANK    = 16,
  parameter int BANK_LAT = 11,
  localparam int BW = $clog2(NBANK),
  localparam int TW = $clog2(BANK_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [BW-1:0]    issue_bank,
  output logic [NBANK-1:0] bank_free
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [TW-1:0] left_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                left_q <= '0;
      else if (issue && issue_bank == BW'(g))    left_q <= TW'(BANK_LAT - 1);
      else if (left_q != '0)                     left_q <= left_q - TW'(1);
    end
    assign bank_free[g] = (left_q == '0);
  end
endmodule

// File: rtl/vec_agu.sv
module vec_agu #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 16,
  parameter int NBANK    = 16,
  parameter int BANK_LAT = 11,
  parameter int MAXLEN   = 64,
  localparam int BW    = $clog2(NBANK),
  localparam int EW    = $clog2(MAXLEN),
  localparam int LEN_W = $clog2(MAXLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_index,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vlen,
  output logic [EW-1:0]     idx_sel,
  input  logic [IDX_W-1:0]  idx_val,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BW-1:0]     req_bank,
  output logic [EW-1:0]     req_elem,
  output logic              busy,
  output logic              done
);
  logic             start_acc;
  logic             issue;
  logic [EW-1:0]    elem;
  logic [ADDR_W-1:0] addr;
  logic [BW-1:0]    bank;
  logic [NBANK-1:0] bank_free;

  function automatic logic [BW-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BW-1:0];
  endfunction

  vagu_ctrl #(.MAXLEN(MAXLEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .issue(issue),
    .start_acc(start_acc), .busy(busy), .done(done), .elem(elem)
  );

  vagu_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .issue(issue),
    .mode_in(mode_index), .base_in(base_addr), .stride_in(stride),
    .idx_val(idx_val), .addr(addr)
  );

  vagu_banks #(.NBANK(NBANK), .BANK_LAT(BANK_LAT)) u_banks (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_bank(bank),
    .bank_free(bank_free)
  );

  assign bank      = bank_of(addr);
  assign issue     = busy && bank_free[bank];
  assign idx_sel   = elem;
  assign req_valid = issue;
  assign req_addr  = addr;
  assign req_bank  = bank;
  assign req_elem  = elem;
endmodule

// File: rtl/vagu_chk.sv
module vagu_chk #(
  parameter int NBANK    = 16,
  parameter int BANK_LAT = 11,
  parameter int EW       = 6,
  localparam int BW = $clog2(NBANK),
  localparam int GW = $clog2(BANK_LAT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          req_valid,
  input logic [BW-1:0] req_bank,
  input logic [EW-1:0] req_elem
);
  logic [GW-1:0] gap [NBANK];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBANK; i++) begin
      if (!rst_n)                                  gap[i] <= GW'(BANK_LAT);
      else if (req_valid && req_bank == BW'(i))    gap[i] <= GW'(1);
      else if (gap[i] < GW'(BANK_LAT))             gap[i] <= gap[i] + GW'(1);
    end
  end

  p_bank_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (gap[req_bank] >= GW'(BANK_LAT)));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_valid) |=> $stable(req_elem));

  p_elem_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!busy || req_elem == $past(req_elem) + EW'(1)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  p_fell_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind vec_agu vagu_chk #(.NBANK(NBANK), .BANK_LAT(BANK_LAT), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .req_valid(req_valid), .req_bank(req_bank), .req_elem(req_elem)
);

// File: tb/sim_vec_agu.sv
module sim_vec_agu;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int IW  = 16;
  localparam int NB  = 16;
  localparam int LAT = 11;
  localparam int ML  = 64;
  localparam int LW  = $clog2(ML + 1);
  localparam int EWB = $clog2(ML);
  localparam int BWB = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_index = 1'b0;
  logic [AW-1:0] base_addr = '0, stride = '0;
  logic [LW-1:0] vlen = '0;
  logic [EWB-1:0] idx_sel;
  logic [IW-1:0] idx_val;
  logic req_valid, busy, done;
  logic [AW-1:0] req_addr;
  logic [BWB-1:0] req_bank;
  logic [EWB-1:0] req_elem;

  logic [IW-1:0] idxmem [ML];
  assign idx_val = idxmem[idx_sel];

  vec_agu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_index(mode_index),
    .base_addr(base_addr), .stride(stride), .vlen(vlen), .idx_sel(idx_sel),
    .idx_val(idx_val), .req_valid(req_valid), .req_addr(req_addr),
    .req_bank(req_bank), .req_elem(req_elem), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0;
  int ready_at [NB];
  int rc_cyc [ML];
  logic [AW-1:0] rc_addr [ML];
  int rc_bank [ML], rc_elem [ML];
  int nrec;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 40000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: actual cycle %0d expected finish before it", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input string rq, input bit im, input logic [AW-1:0] b,
                         input logic [AW-1:0] s, input int vl, input bit poke);
    int c, dcyc, vle, t;
    bit got;
    logic [AW-1:0] ea;
    int eb, et;
    got = 0; nrec = 0; dcyc = 0;
    c = cyc;
    mode_index = im; base_addr = b; stride = s; vlen = LW'(vl); start = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 3000; n++) begin
      start = 1'b0;
      if (poke && n == 2) begin
        start = 1'b1; base_addr = 32'hDEAD_0000; vlen = LW'(3); mode_index = ~im;
      end
      if (req_valid) begin
        if (nrec < ML) begin
          rc_cyc[nrec] = cyc; rc_addr[nrec] = req_addr;
          rc_bank[nrec] = int'(req_bank); rc_elem[nrec] = int'(req_elem);
        end
        nrec++;
      end
      if (done) begin dcyc = cyc; got = 1; break; end
      @(negedge clk);
    end
    start = 1'b0; mode_index = im; base_addr = b;
    chk(rq, "done seen", longint'(got), 1);
    vle = (vl > ML) ? ML : vl;
    chk(vl > ML ? "R12" : "R8", "request count", nrec, vle);
    t = c + 1;
    for (int k = 0; k < vle && k < nrec; k++) begin
      ea = im ? b + AW'(idxmem[k]) : b + AW'(k) * s;
      eb = int'(ea % NB);
      et = (ready_at[eb] > t) ? ready_at[eb] : t;
      chk(rq, "address", rc_addr[k], ea);
      chk("R3", "bank", rc_bank[k], eb);
      chk("R2", "element number", rc_elem[k], k);
      chk("R4", "issue cycle", rc_cyc[k], et);
      ready_at[eb] = et + LAT;
      t = et + 1;
    end
    chk(vle == 0 ? "R9" : "R8", "done cycle", dcyc, t);
    @(negedge clk);
    chk("R8", "done is one pulse", longint'(done), 0);
    chk("R8", "busy after done", longint'(busy), 0);
  endtask

  task automatic t_reset;
    chk("R1", "req_valid at reset", longint'(req_valid), 0);
    chk("R1", "busy at reset", longint'(busy), 0);
    chk("R1", "done at reset", longint'(done), 0);
  endtask

  task automatic t_unit_stride;
    run_vec("R2", 1'b0, 32'h100, 32'd1, 20, 1'b0);
    chk("R5", "unit stride span", rc_cyc[19] - rc_cyc[0], 19);
  endtask

  task automatic t_bank_stride;
    run_vec("R2", 1'b0, 32'h1000, 32'd16, 4, 1'b0);
    chk("R6", "same-bank spacing", rc_cyc[2] - rc_cyc[1], LAT);
  endtask

  task automatic t_even_stride;
    run_vec("R4", 1'b0, 32'h3001, 32'd2, 20, 1'b0);
    chk("R4", "stall after 8 banks", rc_cyc[8] - rc_cyc[0], LAT);
  endtask

  task automatic t_neg_stride;
    run_vec("R2", 1'b0, 32'h10, 32'hFFFF_FFFD, 10, 1'b0);
  endtask

  task automatic t_indexed;
    for (int k = 0; k < ML; k++) idxmem[k] = IW'((k * 37) % 50);
    idxmem[0] = 16'd3; idxmem[1] = 16'd19;
    run_vec("R7", 1'b1, 32'h2000, 32'd0, 12, 1'b0);
    chk("R7", "colliding index spacing", rc_cyc[1] - rc_cyc[0], LAT);
  endtask

  task automatic t_zero_len;
    run_vec("R9", 1'b0, 32'h40, 32'd1, 0, 1'b0);
  endtask

  task automatic t_clamp;
    run_vec("R12", 1'b0, 32'h5000, 32'd1, 100, 1'b0);
  endtask

  task automatic t_busy_start;
    run_vec("R10", 1'b0, 32'h7000, 32'd3, 9, 1'b1);
  endtask

  task automatic t_carry_over;
    int first;
    run_vec("R11", 1'b0, 32'h9000, 32'd0, 1, 1'b0);
    first = rc_cyc[0];
    run_vec("R11", 1'b0, 32'h9010, 32'd0, 1, 1'b0);
    chk("R11", "wait on earlier vector's bank", rc_cyc[0] - first, LAT);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) ready_at[i] = 0;
    for (int k = 0; k < ML; k++) idxmem[k] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unit_stride();
    t_bank_stride();
    t_even_stride();
    t_neg_stride();
    t_indexed();
    t_zero_len();
    t_clamp();
    t_busy_start();
    t_carry_over();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule